// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler Queue

This block is the waiting room between instruction dispatch and the execution units. Each dispatched micro-op brings an identifier, the resource group it must execute on, a fixed execution latency and up to two source operand tags. A slot is taken for it, and the slot passes through three states. It waits while any needed operand is still outstanding. It becomes ready once every operand has been produced. It stays issued from the cycle it leaves for a unit until its fixed latency has run out. The completion is then reported on the writeback port and the slot is released.

Producers announce finished results on broadcast ports, and every waiting slot compares its pending tags against them each cycle. Every resource group can issue one op per cycle. The oldest ready op of the group is chosen, so younger ops can pass older ones that are still waiting. Each group has several equivalent units. A per-group round-robin pointer names the unit for each issue and moves on only when that group actually issues. Occupancy and issue-rate statistics are kept so that queue pressure can be judged after a run.

Top module: `sched_issue_queue`

## Requirements
- R1: An op whose needed sources are all available at dispatch is presented for issue in the next cycle. A source counts as available if it is not needed, if it is flagged available, or if a broadcast in the dispatch cycle carries its tag.
- R2: An op waiting on a tag is presented for issue in the cycle after the broadcast of that tag. A younger op that is already ready may issue before an older op that is still waiting.
- R3: Among the ready ops of one group, the one dispatched first issues first.
- R4: Each group names an issuing unit in 0..UNITS-1. Consecutive issues of a group use consecutive units, wrapping from UNITS-1 to 0, and cycles without an issue in the group leave the pointer unchanged.
- R5: No op issues in the cycle it is dispatched. Each group issues at most one op per cycle, and different groups may issue in the same cycle.
- R6: An op issued in cycle c with latency L (L at least 1) completes in cycle c+L on `wb_valid`/`wb_id`, and its slot is free from the next cycle. When several ops are due at once, the oldest completes first and the others follow in later cycles.
- R7: Issued ops keep their slot until completion. `disp_ready` is low exactly when all DEPTH slots are occupied, and a dispatch offered while it is low is dropped.
- R8: `occ_now` gives the current number of occupied slots. `occ_max` is the highest value `occ_now` has shown in any earlier cycle since reset, and `occ_sum` is the sum of `occ_now` over those earlier cycles.
- R9: `iss_hist[n]` counts the earlier cycles since reset in which exactly n groups issued, for n from 0 to NGRP.
- R10: After reset the queue is empty, `disp_ready` is high, no issue or writeback is signalled, and all statistics are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists |
| disp_id | input | IDW | Op identifier |
| disp_grp | input | log2(NGRP) | Resource group index |
| disp_lat | input | LATW | Execution latency in cycles |
| disp_src_tag | input | NSRC x TAGW | Source operand tags |
| disp_src_need | input | NSRC | Source is used |
| disp_src_rdy | input | NSRC | Source already available |
| bc_valid | input | NBC | Result broadcast valid |
| bc_tag | input | NBC x TAGW | Broadcast result tags |
| iss_valid | output | NGRP | Group issues this cycle |
| iss_id | output | NGRP x IDW | Identifier of the issued op |
| iss_unit | output | NGRP x log2(UNITS) | Unit chosen within the group |
| wb_valid | output | 1 | Completion this cycle |
| wb_id | output | IDW | Identifier of the completing op |
| occ_now | output | log2(DEPTH+1) | Occupied slots |
| occ_max | output | log2(DEPTH+1) | Peak occupancy |
| occ_sum | output | 32 | Occupancy summed over cycles |
| iss_hist | output | (NGRP+1) x 16 | Cycles with exactly n issues |

## Verification
A wrong slot state appears on the issue port within one cycle. A lost wakeup leaves an op that never issues. A stuck issued state shows as a missing completion L cycles after issue, and a slot that is never released leaves `disp_ready` low after the queue should have drained. Wrong age ordering appears at once as a swapped identifier when two ops of a group become ready together. The test sets this up both on the issue port and on the writeback port. A round-robin pointer that drifts on idle cycles shows in the unit number of the next issue after a gap. The statistics are checked against counts the test gathers from the ports in every cycle, so a single missed increment shows up at the final comparison.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_READY  = 2'd2,
        SLOT_ISSUED = 2'd3
    } slot_state_e;

    // Next value of a pointer cycling through 0..lim-1.
    function automatic int wrap_inc(input int cur, input int lim);
        return (cur + 1 >= lim) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/sched_oldest_pick.sv
module sched_oldest_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][N-1:0] older,   // older[a][b]: slot a entered before slot b
    output logic [N-1:0]        grant,
    output logic                any,
    output logic [IW-1:0]       idx
);
    logic [N-1:0] blocked;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && older[j][i]) blocked[i] = 1'b1;
            end
            grant[i] = req[i] && !blocked[i];
        end
    end

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sched_rr_unit.sv
module sched_rr_unit
    import sched_pkg::*;
#(
    parameter int UNITS = 3,
    parameter int UW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [UW-1:0] unit
);
    generate
        if (UNITS > 1) begin : g_multi
            logic [UW-1:0] ptr_q;
            always_ff @(posedge clk) begin
                if (rst)      ptr_q <= '0;
                else if (adv) ptr_q <= UW'(wrap_inc(int'(ptr_q), UNITS));
            end
            assign unit = ptr_q;
        end else begin : g_single
            assign unit = '0;
        end
    endgenerate
endmodule

// File: rtl/sched_occ_stats.sv
module sched_occ_stats #(
    parameter int NGRP = 2,
    parameter int CW   = 4,
    parameter int NW   = 2,
    parameter int HW   = 16,
    parameter int SUMW = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          occ,
    input  logic [NW-1:0]          n_issued,
    output logic [CW-1:0]          occ_max,
    output logic [SUMW-1:0]        occ_sum,
    output logic [NGRP:0][HW-1:0]  hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_max <= '0;
            occ_sum <= '0;
            hist    <= '0;
        end else begin
            if (occ > occ_max) occ_max <= occ;
            occ_sum <= occ_sum + SUMW'(occ);
            for (int b = 0; b <= NGRP; b++) begin
                if (n_issued == NW'(b)) hist[b] <= hist[b] + HW'(1);
            end
        end
    end
endmodule

// File: rtl/sched_issue_queue.sv
module sched_issue_queue
    import sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NSRC  = 2,
    parameter int TAGW  = 6,
    parameter int IDW   = 8,
    parameter int NGRP  = 2,
    parameter int UNITS = 3,
    parameter int NBC   = 2,
    parameter int LATW  = 4
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    disp_valid,
    output logic                                    disp_ready,
    input  logic [IDW-1:0]                          disp_id,
    input  logic [$clog2(NGRP)-1:0]                 disp_grp,
    input  logic [LATW-1:0]                         disp_lat,
    input  logic [NSRC-1:0][TAGW-1:0]               disp_src_tag,
    input  logic [NSRC-1:0]                         disp_src_need,
    input  logic [NSRC-1:0]                         disp_src_rdy,
    input  logic [NBC-1:0]                          bc_valid,
    input  logic [NBC-1:0][TAGW-1:0]                bc_tag,
    output logic [NGRP-1:0]                         iss_valid,
    output logic [NGRP-1:0][IDW-1:0]                iss_id,
    output logic [NGRP-1:0][$clog2(UNITS)-1:0]      iss_unit,
    output logic                                    wb_valid,
    output logic [IDW-1:0]                          wb_id,
    output logic [$clog2(DEPTH+1)-1:0]              occ_now,
    output logic [$clog2(DEPTH+1)-1:0]              occ_max,
    output logic [31:0]                             occ_sum,
    output logic [NGRP:0][15:0]                     iss_hist
);
    localparam int IW = $clog2(DEPTH);
    localparam int GW = $clog2(NGRP);
    localparam int UW = $clog2(UNITS);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(NGRP + 1);

    typedef struct packed {
        logic [IDW-1:0]             id;
        logic [GW-1:0]              grp;
        logic [LATW-1:0]            cnt;
        logic [NSRC-1:0][TAGW-1:0]  tag;
        logic [NSRC-1:0]            pend;
    } slot_t;

    slot_state_e                st_q  [DEPTH];
    slot_t                      ent_q [DEPTH];
    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    logic [DEPTH-1:0]           free_v;
    logic [IW-1:0]              alloc_idx;
    logic                       disp_fire;
    logic [NSRC-1:0]            disp_pend;
    logic [NSRC-1:0]            pend_nxt [DEPTH];
    logic [NGRP-1:0][DEPTH-1:0] grant_m;
    logic [NGRP-1:0][IW-1:0]    pick_idx;
    logic [DEPTH-1:0]           issued_v;
    logic [DEPTH-1:0]           wb_req;
    logic [DEPTH-1:0]           wb_grant;
    logic [IW-1:0]              wb_idx;

    function automatic logic tag_seen(input logic [TAGW-1:0] t);
        logic hit;
        hit = 1'b0;
        for (int b = 0; b < NBC; b++) begin
            if (bc_valid[b] && bc_tag[b] == t) hit = 1'b1;
        end
        return hit;
    endfunction

    // Slot allocation: lowest free slot.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            free_v[i] = (st_q[i] == SLOT_FREE);
            if (free_v[i]) alloc_idx = IW'(i);
        end
    end

    assign disp_ready = |free_v;
    assign disp_fire  = disp_valid && disp_ready;

    // Operand tracking at dispatch and in the queue.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            disp_pend[s] = disp_src_need[s] && !disp_src_rdy[s] && !tag_seen(disp_src_tag[s]);
        end
        for (int i = 0; i < DEPTH; i++) begin
            for (int s = 0; s < NSRC; s++) begin
                pend_nxt[i][s] = ent_q[i].pend[s] && !tag_seen(ent_q[i].tag[s]);
            end
        end
    end

    // Per-group oldest-first selection and unit choice.
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            logic [DEPTH-1:0] req;
            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    req[i] = (st_q[i] == SLOT_READY) && (ent_q[i].grp == GW'(g));
                end
            end
            sched_oldest_pick #(.N(DEPTH), .IW(IW)) u_pick (
                .req   (req),
                .older (older_q),
                .grant (grant_m[g]),
                .any   (iss_valid[g]),
                .idx   (pick_idx[g])
            );
            assign iss_id[g] = ent_q[pick_idx[g]].id;
            sched_rr_unit #(.UNITS(UNITS), .UW(UW)) u_rr (
                .clk  (clk),
                .rst  (rst),
                .adv  (iss_valid[g]),
                .unit (iss_unit[g])
            );
        end
    endgenerate

    always_comb begin
        issued_v = '0;
        for (int g = 0; g < NGRP; g++) issued_v = issued_v | grant_m[g];
        for (int i = 0; i < DEPTH; i++) begin
            wb_req[i] = (st_q[i] == SLOT_ISSUED) && (ent_q[i].cnt == '0);
        end
    end

    // Completion: oldest due op first.
    sched_oldest_pick #(.N(DEPTH), .IW(IW)) u_wb_pick (
        .req   (wb_req),
        .older (older_q),
        .grant (wb_grant),
        .any   (wb_valid),
        .idx   (wb_idx)
    );
    assign wb_id = ent_q[wb_idx].id;

    // Slot state machine and age matrix.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= SLOT_FREE;
                ent_q[i] <= '0;
            end
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                unique case (st_q[i])
                    SLOT_FREE: begin
                        if (disp_fire && alloc_idx == IW'(i)) begin
                            ent_q[i].id   <= disp_id;
                            ent_q[i].grp  <= disp_grp;
                            ent_q[i].cnt  <= disp_lat;
                            ent_q[i].tag  <= disp_src_tag;
                            ent_q[i].pend <= disp_pend;
                            st_q[i]       <= (|disp_pend) ? SLOT_WAIT : SLOT_READY;
                        end
                    end
                    SLOT_WAIT: begin
                        ent_q[i].pend <= pend_nxt[i];
                        if (!(|pend_nxt[i])) st_q[i] <= SLOT_READY;
                    end
                    SLOT_READY: begin
                        if (issued_v[i]) begin
                            st_q[i]      <= SLOT_ISSUED;
                            ent_q[i].cnt <= (ent_q[i].cnt == '0) ? '0 : ent_q[i].cnt - LATW'(1);
                        end
                    end
                    SLOT_ISSUED: begin
                        if (wb_grant[i])              st_q[i] <= SLOT_FREE;
                        else if (ent_q[i].cnt != '0)  ent_q[i].cnt <= ent_q[i].cnt - LATW'(1);
                    end
                    default: st_q[i] <= SLOT_FREE;
                endcase
            end
            if (disp_fire) begin
                for (int j = 0; j < DEPTH; j++) begin
                    older_q[alloc_idx][j] <= 1'b0;
                    older_q[j][alloc_idx] <= !free_v[j];
                end
            end
        end
    end

    assign occ_now = CW'($countones(~free_v));

    sched_occ_stats #(.NGRP(NGRP), .CW(CW), .NW(NW), .HW(16), .SUMW(32)) u_stats (
        .clk      (clk),
        .rst      (rst),
        .occ      (occ_now),
        .n_issued (NW'($countones(iss_valid))),
        .occ_max  (occ_max),
        .occ_sum  (occ_sum),
        .hist     (iss_hist)
    );
endmodule

// File: rtl/sched_issue_queue_chk.sv
module sched_issue_queue_chk #(
    parameter int DEPTH = 8,
    parameter int NGRP  = 2,
    parameter int UNITS = 3
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                disp_valid,
    input logic                                disp_ready,
    input logic [NGRP-1:0]                     iss_valid,
    input logic [NGRP-1:0][$clog2(UNITS)-1:0]  iss_unit,
    input logic                                wb_valid,
    input logic [$clog2(DEPTH+1)-1:0]          occ_now,
    input logic [$clog2(DEPTH+1)-1:0]          occ_max
);
    localparam int CW = $clog2(DEPTH + 1);

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (rst)
        occ_now <= CW'(DEPTH));

    p_full_backpressure_r7: assert property (@(posedge clk) disable iff (rst)
        !disp_ready |-> occ_now == CW'(DEPTH));

    p_enqueue_count_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !wb_valid) |=> occ_now == $past(occ_now) + CW'(1));

    p_release_count_r6: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !(disp_valid && disp_ready)) |=> occ_now == $past(occ_now) - CW'(1));

    p_empty_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        occ_now == '0 |-> (iss_valid == '0 && !wb_valid));

    p_peak_monotone_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occ_max >= $past(occ_max));

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_rr
            p_rr_step_r4: assert property (@(posedge clk) disable iff (rst)
                iss_valid[g] |=> (!iss_valid[g] ||
                    int'(iss_unit[g]) == (int'($past(iss_unit[g])) + 1) % UNITS));
            p_rr_hold_r4: assert property (@(posedge clk) disable iff (rst)
                !iss_valid[g] |=> iss_unit[g] == $past(iss_unit[g]));
        end
    endgenerate
endmodule

bind sched_issue_queue sched_issue_queue_chk #(
    .DEPTH (DEPTH),
    .NGRP  (NGRP),
    .UNITS (UNITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .iss_valid  (iss_valid),
    .iss_unit   (iss_unit),
    .wb_valid   (wb_valid),
    .occ_now    (occ_now),
    .occ_max    (occ_max)
);

// File: tb/sched_issue_queue_test.sv
module sched_issue_queue_test;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             disp_valid;
    logic             disp_ready;
    logic [7:0]       disp_id;
    logic [0:0]       disp_grp;
    logic [3:0]       disp_lat;
    logic [1:0][5:0]  disp_src_tag;
    logic [1:0]       disp_src_need;
    logic [1:0]       disp_src_rdy;
    logic [1:0]       bc_valid;
    logic [1:0][5:0]  bc_tag;
    logic [1:0]       iss_valid;
    logic [1:0][7:0]  iss_id;
    logic [1:0][1:0]  iss_unit;
    logic             wb_valid;
    logic [7:0]       wb_id;
    logic [3:0]       occ_now;
    logic [3:0]       occ_max;
    logic [31:0]      occ_sum;
    logic [2:0][15:0] iss_hist;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    int hist_m [3];
    int sum_m  = 0;
    int max_m  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sched_issue_queue uut (
        .clk (clk), .rst (rst),
        .disp_valid (disp_valid), .disp_ready (disp_ready), .disp_id (disp_id),
        .disp_grp (disp_grp), .disp_lat (disp_lat), .disp_src_tag (disp_src_tag),
        .disp_src_need (disp_src_need), .disp_src_rdy (disp_src_rdy),
        .bc_valid (bc_valid), .bc_tag (bc_tag),
        .iss_valid (iss_valid), .iss_id (iss_id), .iss_unit (iss_unit),
        .wb_valid (wb_valid), .wb_id (wb_id),
        .occ_now (occ_now), .occ_max (occ_max), .occ_sum (occ_sum), .iss_hist (iss_hist)
    );

    // Port-level tally for R8 / R9.
    always @(negedge clk) begin
        if (mon_on) begin
            hist_m[$countones(iss_valid)] = hist_m[$countones(iss_valid)] + 1;
            sum_m = sum_m + int'(occ_now);
            if (int'(occ_now) > max_m) max_m = int'(occ_now);
        end
    end

    typedef struct packed {
        logic       grp;
        logic [3:0] lat;
        logic       need;
        logic       rdy;
        logic [3:0] bcd;
        logic [3:0] xiss;
        logic [3:0] xwb;
    } row_t;

    // grp, lat, need, rdy, broadcast delay, expected issue cycle, expected writeback cycle
    localparam int NROW = 6;
    localparam row_t ROWS [NROW] = '{
        '{1'b0, 4'd1, 1'b0, 1'b0, 4'd0, 4'd1, 4'd2},
        '{1'b1, 4'd3, 1'b0, 1'b0, 4'd0, 4'd1, 4'd4},
        '{1'b0, 4'd2, 1'b1, 1'b0, 4'd0, 4'd1, 4'd3},
        '{1'b1, 4'd1, 1'b1, 1'b0, 4'd3, 4'd4, 4'd5},
        '{1'b0, 4'd5, 1'b1, 1'b0, 4'd1, 4'd2, 4'd7},
        '{1'b1, 4'd2, 1'b1, 1'b1, 4'd0, 4'd1, 4'd3}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        disp_valid = 1'b0; disp_id = '0; disp_grp = '0; disp_lat = 4'd1;
        disp_src_tag = '0; disp_src_need = '0; disp_src_rdy = '0;
        bc_valid = '0; bc_tag = '0;
    endtask

    task automatic step();
        @(negedge clk);
        clr();
    endtask

    task automatic put(input logic [7:0] id, input logic g, input logic [3:0] lat,
                       input logic nd, input logic rd, input logic [5:0] tg);
        disp_valid = 1'b1; disp_id = id; disp_grp = g; disp_lat = lat;
        disp_src_need = {1'b0, nd}; disp_src_rdy = {1'b0, rd};
        disp_src_tag[0] = tg; disp_src_tag[1] = 6'd0;
    endtask

    task automatic bcast(input int slot, input logic [5:0] tg);
        bc_valid[slot] = 1'b1; bc_tag[slot] = tg;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int u0, wbs, saw_bad;
        for (int b = 0; b < 3; b++) hist_m[b] = 0;
        clr();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mon_on = 1'b1;

        // R10: reset state
        chk(disp_ready == 1'b1, "R10 disp_ready", int'(disp_ready), 1);
        chk(iss_valid == 2'b00 && !wb_valid, "R10 no issue/wb", int'(iss_valid), 0);
        chk(occ_now == 0 && occ_max == 0 && occ_sum == 0, "R10 occupancy stats", int'(occ_now), 0);
        chk(iss_hist == '0, "R10 histogram", int'(iss_hist[0]), 0);

        // R1 / R2 / R6: table of single-op timings
        for (int r = 0; r < NROW; r++) begin
            int got_iss, got_wb;
            got_iss = -1; got_wb = -1;
            for (int t = 0; t < 10; t++) begin
                step();
                if (t > 0) begin
                    if (iss_valid[ROWS[r].grp] && got_iss < 0) begin
                        got_iss = t;
                        chk(iss_id[ROWS[r].grp] == 8'(8'h10 + r), "R1 issue id",
                            int'(iss_id[ROWS[r].grp]), 16 + r);
                    end
                    if (wb_valid && got_wb < 0) begin
                        got_wb = t;
                        chk(wb_id == 8'(8'h10 + r), "R6 writeback id", int'(wb_id), 16 + r);
                    end
                end
                if (t == 9) chk(occ_now == 0, "R6 slot released", int'(occ_now), 0);
                if (t == 0) put(8'(8'h10 + r), ROWS[r].grp, ROWS[r].lat, ROWS[r].need,
                                ROWS[r].rdy, 6'(r + 1));
                if (ROWS[r].need && !ROWS[r].rdy && t == int'(ROWS[r].bcd)) bcast(1, 6'(r + 1));
            end
            chk(got_iss == int'(ROWS[r].xiss), (ROWS[r].need && !ROWS[r].rdy) ? "R2 issue cycle" : "R1 issue cycle",
                got_iss, int'(ROWS[r].xiss));
            chk(got_wb == int'(ROWS[r].xwb), "R6 writeback cycle", got_wb, int'(ROWS[r].xwb));
        end

        // R2 / R3 / R5: bypass of a waiting op, then oldest-first
        step(); put(8'h40, 1'b0, 4'd1, 1'b1, 1'b0, 6'd20);
        step(); put(8'h41, 1'b0, 4'd1, 1'b1, 1'b0, 6'd21);
        step(); put(8'h42, 1'b0, 4'd1, 1'b0, 1'b0, 6'd0);
        step();
        chk(iss_valid[0] && iss_id[0] == 8'h42, "R2 younger ready op passes", int'(iss_id[0]), 'h42);
        bcast(0, 6'd21); bcast(1, 6'd20);
        step();
        chk(iss_valid[0] && iss_id[0] == 8'h40, "R3 oldest first", int'(iss_id[0]), 'h40);
        chk(iss_valid[1] == 1'b0, "R5 other group idle", int'(iss_valid[1]), 0);
        step();
        chk(iss_valid[0] && iss_id[0] == 8'h41, "R3 younger next", int'(iss_id[0]), 'h41);
        repeat (4) step();

        // R4: round-robin units, no advance on idle cycles
        step(); put(8'h50, 1'b1, 4'd1, 1'b0, 1'b0, 6'd0);
        step(); put(8'h51, 1'b1, 4'd1, 1'b0, 1'b0, 6'd0);
        u0 = int'(iss_unit[1]);
        chk(iss_valid[1] && iss_id[1] == 8'h50, "R4 first issue", int'(iss_id[1]), 'h50);
        step();
        chk(iss_valid[1] && int'(iss_unit[1]) == (u0 + 1) % 3, "R4 next unit", int'(iss_unit[1]), (u0 + 1) % 3);
        repeat (3) step();
        put(8'h52, 1'b1, 4'd1, 1'b0, 1'b0, 6'd0);
        step();
        chk(iss_valid[1] && int'(iss_unit[1]) == (u0 + 2) % 3, "R4 unit after gap", int'(iss_unit[1]), (u0 + 2) % 3);
        repeat (3) step();

        // R5: both groups in one cycle
        step(); put(8'h60, 1'b0, 4'd1, 1'b1, 1'b0, 6'd30);
        step(); put(8'h61, 1'b1, 4'd1, 1'b1, 1'b0, 6'd31);
        step(); bcast(0, 6'd30); bcast(1, 6'd31);
        step();
        chk(iss_valid == 2'b11, "R5 dual-group issue", int'(iss_valid), 3);
        repeat (3) step();

        // R6: simultaneous completion, oldest first
        step(); put(8'h70, 1'b0, 4'd3, 1'b0, 1'b0, 6'd0);
        step(); put(8'h71, 1'b1, 4'd2, 1'b0, 1'b0, 6'd0);
        step(); step(); step();
        chk(wb_valid && wb_id == 8'h70, "R6 oldest completes first", int'(wb_id), 'h70);
        step();
        chk(wb_valid && wb_id == 8'h71, "R6 deferred completion", int'(wb_id), 'h71);
        repeat (3) step();

        // R7: queue fills with issued ops; offered dispatch dropped
        for (int k = 0; k < 8; k++) begin
            step(); put(8'(8'h80 + k), 1'(k % 2), 4'd15, 1'b0, 1'b0, 6'd0);
        end
        step();
        chk(disp_ready == 1'b0, "R7 full backpressure", int'(disp_ready), 0);
        chk(occ_now == 8, "R7 issued ops hold slots", int'(occ_now), 8);
        put(8'hEE, 1'b0, 4'd1, 1'b0, 1'b0, 6'd0);
        step();
        chk(occ_now == 8, "R7 dispatch while full dropped", int'(occ_now), 8);
        wbs = 0; saw_bad = 0;
        for (int t = 0; t < 40; t++) begin
            step();
            if (wb_valid) begin
                wbs++;
                if (wb_id == 8'hEE) saw_bad = 1;
            end
            if ((iss_valid[0] && iss_id[0] == 8'hEE) || (iss_valid[1] && iss_id[1] == 8'hEE)) saw_bad = 1;
        end
        chk(wbs == 8, "R6 all completions seen", wbs, 8);
        chk(saw_bad == 0, "R7 dropped op never appears", saw_bad, 0);
        chk(disp_ready == 1'b1 && occ_now == 0, "R7 drained", int'(occ_now), 0);

        // R8 / R9: statistics against port tally
        @(posedge clk);
        #1;
        chk(int'(occ_max) == max_m && max_m == 8, "R8 peak occupancy", int'(occ_max), 8);
        chk(int'(occ_sum) == sum_m, "R8 occupancy sum", int'(occ_sum), sum_m);
        for (int b = 0; b < 3; b++) begin
            chk(int'(iss_hist[b]) == hist_m[b], "R9 issue histogram", int'(iss_hist[b]), hist_m[b]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule